// File: doc/BRIEF.md
# Split Dual 8-Bit Reload Timer

This block is the split-mode core of a timer peripheral. With split mode on it behaves as two separate 8-bit up-counters, a low half and a high half. When a half rolls over from 0xFF, it loads the value held in its own reload register. Each half takes its count ticks either straight from the system tick or from a source chosen by a shared select field. The candidate sources are the system tick divided by twelve, the real-time tick, and the external tick divided by eight. Every source reaches the counters as a synchronous enable in one clock domain.

A rollover sets a sticky flag for that half. Software clears a flag by writing a zero to it. One level-sensitive interrupt request combines the two flags under two enable bits. A low-half rollover also raises a one-cycle trigger for an external converter. Configuration enters through a plain register write strobe. That strobe carries no stream data, so it has no valid/ready handshake and no back-pressure: every strobe is taken in the cycle it is presented.

Top module: `split_reload_timer`

## Requirements
- R1: After reset both counts, both reload registers, the control byte, both flags, the interrupt and the trigger are 0.
- R2: While the split-enable control bit is 0, neither count changes.
- R3: With split enable set, the low half counts on its ticks whatever the run bit holds. The high half counts only while the run bit is 1.
- R4: A half that receives a tick while at 0xFF loads its own reload value in the next cycle. Any other tick adds one.
- R5: When a half's mode bit is 1, that half counts on every cycle in which sys_tick is high.
- R6: When a half's mode bit is 0, select field code 00 gives one tick on every 12th sys_tick. Code 01 gives rtc_tick. Code 11 gives one tick on every 8th ext_tick. Code 10 gives no ticks. Both dividers run freely from reset and are shared by the halves.
- R7: A half's flag goes to 1 in the cycle after its rollover and stays at 1. A write to address 3 clears the low flag when data bit 0 is 0 and the high flag when data bit 1 is 0. Writing a 1 leaves the flag unchanged.
- R8: When a rollover and a clear of the same flag fall in the same cycle, the flag ends up at 1.
- R9: irq equals irq_en AND (high flag OR (low-irq enable AND low flag)).
- R10: conv_trig is high for exactly the cycle after each low-half rollover.
- R11: Write addresses are 0 for the low reload, 1 for the high reload, 2 for control and 3 for flag clear. The control bits are: bit 0 split enable, bit 1 run, bit 2 low mode, bit 3 high mode, bits 5:4 select field, bit 6 low-irq enable, bit 7 irq enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| sys_tick | input | 1 | System clock tick enable |
| ext_tick | input | 1 | External clock tick enable |
| rtc_tick | input | 1 | Real-time clock tick enable |
| cnt_lo | output | 8 | Low half count |
| cnt_hi | output | 8 | High half count |
| flag_lo | output | 1 | Low half sticky overflow flag |
| flag_hi | output | 1 | High half sticky overflow flag |
| irq | output | 1 | Combined interrupt request (level) |
| conv_trig | output | 1 | One-cycle pulse after a low-half rollover |

## Verification
A hardware flag set and a software clear of the same flag can land in one cycle. The same cycle can also hold a reload-register write and the rollover that reads that register. To provoke the first case, the bench loads 0xFF into both reload registers and puts both halves on the system tick held high, so every cycle is a rollover. It then writes a clear on every cycle. The flags must stay at 1, and irq must stay asserted throughout. The bench judges every cycle against a cycle model built from the requirements, and it sweeps all four select codes and all four interrupt-enable combinations under pseudo-random tick patterns.

// File: rtl/srt_pkg.sv
package srt_pkg;
  localparam int unsigned CNT_W = 8;

  localparam logic [1:0] ADDR_RL_LO = 2'd0;
  localparam logic [1:0] ADDR_RL_HI = 2'd1;
  localparam logic [1:0] ADDR_CTRL  = 2'd2;
  localparam logic [1:0] ADDR_FLAGS = 2'd3;

  typedef enum logic [1:0] {
    SRC_DIV_SYS = 2'b00,
    SRC_RTC     = 2'b01,
    SRC_NONE    = 2'b10,
    SRC_DIV_EXT = 2'b11
  } src_sel_e;

  typedef struct packed {
    logic     irq_en;
    logic     lo_irq_en;
    src_sel_e sel;
    logic     mode_hi;
    logic     mode_lo;
    logic     run_hi;
    logic     split_en;
  } srt_ctrl_t;
endpackage

// File: rtl/srt_prescaler.sv
module srt_prescaler #(
  parameter int unsigned DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_tick,
  output logic out_tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last  = (cnt_q == LAST);
  assign out_tick = in_tick & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (in_tick) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/srt_src_sel.sv
module srt_src_sel
  import srt_pkg::*;
(
  input  logic     mode_sys,
  input  src_sel_e sel,
  input  logic     sys_tick,
  input  logic     div_sys_tick,
  input  logic     rtc_tick,
  input  logic     div_ext_tick,
  output logic     tick
);
  always_comb begin
    if (mode_sys) tick = sys_tick;
    else begin
      unique case (sel)
        SRC_DIV_SYS: tick = div_sys_tick;
        SRC_RTC:     tick = rtc_tick;
        SRC_DIV_EXT: tick = div_ext_tick;
        default:     tick = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/srt_half.sv
module srt_half #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  assign ovf = en & (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (en)  cnt <= ovf ? reload : cnt + 1'b1;
  end
endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer
  import srt_pkg::*;
#(
  parameter int unsigned DIV_SYS = 12,
  parameter int unsigned DIV_EXT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             sys_tick,
  input  logic             ext_tick,
  input  logic             rtc_tick,
  output logic [CNT_W-1:0] cnt_lo,
  output logic [CNT_W-1:0] cnt_hi,
  output logic             flag_lo,
  output logic             flag_hi,
  output logic             irq,
  output logic             conv_trig
);
  localparam int unsigned NH = 2;

  srt_ctrl_t                  ctrl_q;
  logic [NH-1:0][CNT_W-1:0]   rl_q;
  logic [NH-1:0][CNT_W-1:0]   cnt_v;
  logic [NH-1:0]              mode_v, gate_v, src_v, ovf_v;
  logic [NH-1:0]              flag_q, flag_d;
  logic                       conv_q;
  logic                       div_sys_tick, div_ext_tick;
  logic                       split_on, run_on, irq_on;

  assign split_on = ctrl_q.split_en;
  assign run_on   = ctrl_q.run_hi;
  assign irq_on   = ctrl_q.irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rl_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_RL_LO: rl_q[0] <= wr_data;
        ADDR_RL_HI: rl_q[1] <= wr_data;
        ADDR_CTRL:  ctrl_q  <= srt_ctrl_t'(wr_data);
        default:    ;
      endcase
    end
  end

  srt_prescaler #(.DIV(DIV_SYS)) u_div_sys (
    .clk(clk), .rst_n(rst_n), .in_tick(sys_tick), .out_tick(div_sys_tick));
  srt_prescaler #(.DIV(DIV_EXT)) u_div_ext (
    .clk(clk), .rst_n(rst_n), .in_tick(ext_tick), .out_tick(div_ext_tick));

  assign mode_v = {ctrl_q.mode_hi, ctrl_q.mode_lo};
  assign gate_v = {ctrl_q.split_en & ctrl_q.run_hi, ctrl_q.split_en};

  for (genvar h = 0; h < NH; h++) begin : g_half
    srt_src_sel u_sel (
      .mode_sys(mode_v[h]), .sel(ctrl_q.sel), .sys_tick(sys_tick),
      .div_sys_tick(div_sys_tick), .rtc_tick(rtc_tick),
      .div_ext_tick(div_ext_tick), .tick(src_v[h]));

    srt_half #(.W(CNT_W)) u_half (
      .clk(clk), .rst_n(rst_n), .en(src_v[h] & gate_v[h]),
      .reload(rl_q[h]), .cnt(cnt_v[h]), .ovf(ovf_v[h]));

    always_comb begin
      flag_d[h] = flag_q[h];
      if (wr_en && wr_addr == ADDR_FLAGS && !wr_data[h]) flag_d[h] = 1'b0;
      if (ovf_v[h]) flag_d[h] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      conv_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      conv_q <= ovf_v[0];
    end
  end

  assign cnt_lo    = cnt_v[0];
  assign cnt_hi    = cnt_v[1];
  assign flag_lo   = flag_q[0];
  assign flag_hi   = flag_q[1];
  assign conv_trig = conv_q;
  assign irq       = ctrl_q.irq_en & (flag_q[1] | (ctrl_q.lo_irq_en & flag_q[0]));
endmodule

// File: rtl/srt_checker.sv
module srt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] cnt_lo,
  input logic [7:0] cnt_hi,
  input logic       flag_lo,
  input logic       flag_hi,
  input logic       irq,
  input logic       conv_trig,
  input logic       split_on,
  input logic       run_on,
  input logic       irq_on
);
  // R2
  split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !split_on |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  // R3
  hi_run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_on |=> $stable(cnt_hi));

  // R7
  flag_hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_hi && !(wr_en && wr_addr == 2'd3 && !wr_data[1])) |=> flag_hi);

  // R7
  flag_lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_lo && !(wr_en && wr_addr == 2'd3 && !wr_data[0])) |=> flag_lo);

  // R8
  trig_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_trig |-> flag_lo);

  // R9
  irq_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_on |-> !irq);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_hi || flag_lo));
endmodule

bind split_reload_timer srt_checker u_srt_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
  .flag_lo(flag_lo), .flag_hi(flag_hi), .irq(irq), .conv_trig(conv_trig),
  .split_on(split_on), .run_on(run_on), .irq_on(irq_on));

// File: tb/tb_split_reload_timer.sv
module tb_split_reload_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sys_tick = 1'b0, ext_tick = 1'b0, rtc_tick = 1'b0;
  logic [7:0] cnt_lo, cnt_hi;
  logic       flag_lo, flag_hi, irq, conv_trig;

  int checks = 0, fails = 0;
  bit done = 0;
  bit tick_on = 0;
  bit sys_force = 0;
  logic [15:0] lfsr = 16'hACE1;

  // bench model, built from the requirements
  int         m12 = 0, m8 = 0;
  logic [7:0] mc [2] = '{8'h00, 8'h00};
  logic [7:0] mrl[2] = '{8'h00, 8'h00};
  logic [7:0] mctl = 8'h00;
  logic [1:0] mf = 2'b00;
  logic       mtrig = 1'b0;
  logic       t12, t8, src, gate;
  logic [1:0] ov;

  always #2.5 clk = ~clk;

  split_reload_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sys_tick(sys_tick), .ext_tick(ext_tick),
    .rtc_tick(rtc_tick), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .flag_lo(flag_lo), .flag_hi(flag_hi), .irq(irq), .conv_trig(conv_trig));

  always @(posedge clk) begin
    if (!rst_n) begin
      m12 = 0; m8 = 0; mc[0] = 0; mc[1] = 0; mrl[0] = 0; mrl[1] = 0;
      mctl = 0; mf = 0; mtrig = 0;
    end else begin
      t12 = sys_tick && (m12 == 11);
      t8  = ext_tick && (m8 == 7);
      if (sys_tick) m12 = (m12 == 11) ? 0 : m12 + 1;
      if (ext_tick) m8  = (m8 == 7) ? 0 : m8 + 1;
      for (int h = 0; h < 2; h++) begin
        if (mctl[2+h]) src = sys_tick;
        else case (mctl[5:4])
          2'b00: src = t12;
          2'b01: src = rtc_tick;
          2'b11: src = t8;
          default: src = 1'b0;
        endcase
        gate = mctl[0] && (h == 0 || mctl[1]);
        ov[h] = gate && src && (mc[h] == 8'hFF);
        if (gate && src) mc[h] = ov[h] ? mrl[h] : mc[h] + 8'd1;
      end
      if (wr_en && wr_addr == 2'd3) mf = mf & wr_data[1:0];
      mf = mf | ov;
      mtrig = ov[0];
      if (wr_en && wr_addr == 2'd0) mrl[0] = wr_data;
      if (wr_en && wr_addr == 2'd1) mrl[1] = wr_data;
      if (wr_en && wr_addr == 2'd2) mctl = wr_data;
    end
  end

  function automatic logic model_irq();
    return mctl[7] & (mf[1] | (mctl[6] & mf[0]));
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (cnt_lo !== mc[0] || cnt_hi !== mc[1] || flag_lo !== mf[0] ||
        flag_hi !== mf[1] || irq !== model_irq() || conv_trig !== mtrig) begin
      fails++;
      $display("FAIL %s: actual lo=%h hi=%h fl=%b fh=%b irq=%b trig=%b expected lo=%h hi=%h fl=%b fh=%b irq=%b trig=%b",
               tag, cnt_lo, cnt_hi, flag_lo, flag_hi, irq, conv_trig,
               mc[0], mc[1], mf[0], mf[1], model_irq(), mtrig);
    end
  endtask

  task automatic drive_ticks();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    sys_tick = tick_on && (sys_force || lfsr[0] || lfsr[5]);
    ext_tick = tick_on && lfsr[3];
    rtc_tick = tick_on && lfsr[7] && lfsr[2];
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare(tag);
      wr_en = 1'b0;
      drive_ticks();
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    compare(tag);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    drive_ticks();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    idle(3, "R1");
    tick_on = 1;
    // R11 register map, R2 split off holds
    wr(2'd0, 8'hF0, "R11");
    wr(2'd1, 8'hFA, "R11");
    wr(2'd2, 8'h8E, "R2");
    idle(200, "R2");
    // R5 both halves on system tick, R4 reload, R10 trigger
    wr(2'd2, 8'h8F, "R5");
    idle(400, "R4 R5 R10");
    // R6 select sweep
    for (int s = 0; s < 4; s++) begin
      wr(2'd2, 8'hC3 | 8'(s << 4), "R6");
      wr(2'd3, 8'h00, "R7");
      idle(700, "R6 R10");
    end
    // R3 run off: low counts, high holds
    wr(2'd2, 8'hCD, "R3");
    idle(300, "R3");
    // R9 interrupt enable combinations, R7 selective clears
    for (int k = 0; k < 4; k++) begin
      wr(2'd2, {k[1], k[0], 6'b001111}, "R9");
      wr(2'd3, 8'h00, "R7");
      idle(150, "R9");
      wr(2'd3, 8'h02, "R7");
      idle(5, "R7 R9");
      wr(2'd3, 8'h01, "R7");
      idle(150, "R9");
    end
    // R8 clear colliding with a rollover every cycle
    wr(2'd0, 8'hFF, "R8");
    wr(2'd1, 8'hFF, "R8");
    wr(2'd2, 8'h8F, "R8");
    sys_force = 1;
    idle(300, "R8");
    for (int i = 0; i < 50; i++) wr(2'd3, 8'h00, "R8 R9");
    idle(5, "R8");
    finish_run();
  end
endmodule